// File: doc/BRIEF.md
# Bus Ownership and Parking Controller

This block is the bridge's own bus-ownership interface for use with an arbiter outside the chip. The internal master signals that it has a transaction waiting. The block then raises an active-low request pin, watches the active-low grant pin, and issues a one-clock start strobe to the transaction datapath once the grant is seen on an idle bus. The request pin is the output that would otherwise carry grant 0. The grant pin is the input that would otherwise carry request 0. The spare grant outputs are held high.

When the bridge holds the grant on an idle bus and is not requesting, it parks the bus. The address/data and command/byte-enable lines are enabled first, and parity follows a configurable number of clocks later. The parked values are all zeros, with the matching even parity bit of 0. Parking ends on the clock after the grant is sampled high. A pending transaction may also start directly from the parked state while the grant is still held.

The datapath combines the enables from this block with its own drive enables during a transaction. Parity generation and data transfer sequencing are outside this block.

Top module: `bus_own_ctl`

## Requirements
- R1: After reset, `req_n_o` is 1, `start_o` is 0, all three park enables are 0 and every bit of `spare_gnt_n_o` is 1.
- R2: The address/data and byte-enable park enables go to 1 on the clock after an edge that samples all of the following: `gnt_n_i`=0, `frame_n_i`=1, `irdy_n_i`=1, and no own request pending. They stay 0 while either bus strobe is sampled 0, and while the block is requesting.
- R3: The parity park enable goes to 1 exactly PAR_LAG clocks (default 1) after the address/data enable, and only while parking continues without a break.
- R4: On the clock after an edge that samples `gnt_n_i`=1, all park enables are 0.
- R5: An edge that samples `mst_req_i`=1 while the block is not parked with the grant drives `req_n_o` to 0 after that edge. If `mst_req_i` falls before the block starts, `req_n_o` returns to 1 after the next edge.
- R6: `start_o` is a one-clock pulse after an edge that samples request active, `gnt_n_i`=0, `frame_n_i`=1 and `irdy_n_i`=1. While either strobe is sampled 0, no start is issued and the request is held.
- R7: If the block is parking and samples `mst_req_i`=1 with `gnt_n_i` still 0 on an idle bus, `start_o` and `req_n_o`=0 appear after that same edge, and the park enables drop at that time.
- R8: After `frame_n_i` is sampled 0 following a start, `req_n_o` returns to 1 unless `mst_req_i` is 1 (another transaction is queued). In that case the request stays 0 and a new start follows once the bus is idle and granted.
- R9: `spare_gnt_n_o` is all ones at all times. `park_ad_o` and `park_cbe_o` are all zeros, and `park_par_o` is their even parity, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req_i | input | 1 | Internal master has a transaction waiting |
| gnt_n_i | input | 1 | Active-low grant from the outside arbiter (request-0 pin) |
| frame_n_i | input | 1 | Bus frame strobe, active low |
| irdy_n_i | input | 1 | Bus initiator-ready strobe, active low |
| req_n_o | output | 1 | Active-low bus request (grant-0 pin) |
| start_o | output | 1 | One-clock strobe to begin a transaction |
| ad_oe_o | output | 1 | Park enable for address/data lines |
| cbe_oe_o | output | 1 | Park enable for command/byte-enable lines |
| par_oe_o | output | 1 | Park enable for parity line |
| park_ad_o | output | AD_W | Value driven on address/data while parked |
| park_cbe_o | output | CBE_W | Value driven on byte-enables while parked |
| park_par_o | output | 1 | Value driven on parity while parked |
| spare_gnt_n_o | output | N_SPARE | Unused grant outputs, held high |

## Verification
The scoreboard expects the parity enable to lag the address/data enable by exactly one clock. A design that staged the enables together would enable parity too early, and one with an extra register would enable it too late. Grants that arrive while frame or ready is low check that neither parking nor a start happens on a busy bus. A design that ignored ready would park or start over another master's data phase. The direct start from the parked state checks that request and start appear after one edge and that the park enables drop at that time. A queued second transaction checks that the request is held through the first transaction rather than dropped and raised again.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_REQ  = 2'd1,
      OWN_ADDR = 2'd2,
      OWN_XFER = 2'd3
   } own_state_e;

   function automatic logic even_par(input logic [63:0] ad, input logic [7:0] cbe);
      even_par = (^ad) ^ (^cbe);
   endfunction

endpackage

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
   import bus_own_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mst_req_i,
   input  logic       gnt_n_i,
   input  logic       idle_i,
   input  logic       frame_n_i,
   input  logic       parked_i,
   output logic       req_d_o,
   output logic       to_idle_o,
   output logic       req_n_o,
   output logic       start_o
);

   own_state_e state_q, state_d;
   logic       start_d;

   always_comb begin
      state_d = state_q;
      start_d = 1'b0;
      unique case (state_q)
         OWN_IDLE: begin
            if (mst_req_i) begin
               if (parked_i && !gnt_n_i && idle_i) begin
                  state_d = OWN_ADDR;
                  start_d = 1'b1;
               end else begin
                  state_d = OWN_REQ;
               end
            end
         end
         OWN_REQ: begin
            if (!mst_req_i) begin
               state_d = OWN_IDLE;
            end else if (!gnt_n_i && idle_i) begin
               state_d = OWN_ADDR;
               start_d = 1'b1;
            end
         end
         OWN_ADDR: begin
            if (!frame_n_i) state_d = OWN_XFER;
         end
         OWN_XFER: begin
            if (idle_i) state_d = mst_req_i ? OWN_REQ : OWN_IDLE;
         end
         default: state_d = OWN_IDLE;
      endcase
   end

   assign req_d_o   = (state_d == OWN_REQ) || (state_d == OWN_ADDR) ||
                      ((state_d == OWN_XFER) && mst_req_i);
   assign to_idle_o = (state_d == OWN_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OWN_IDLE;
         req_n_o <= 1'b1;
         start_o <= 1'b0;
      end else begin
         state_q <= state_d;
         req_n_o <= !req_d_o;
         start_o <= start_d;
      end
   end

endmodule

// File: rtl/bus_own_park.sv
module bus_own_park #(
   parameter int PAR_LAG = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gnt_n_i,
   input  logic idle_i,
   input  logic req_d_i,
   input  logic to_idle_i,
   output logic parked_o,
   output logic ad_oe_o,
   output logic cbe_oe_o,
   output logic par_oe_o
);

   logic               park_d;
   logic [PAR_LAG-1:0] chain_q;
   logic               par_q;

   assign park_d = !gnt_n_i && idle_i && !req_d_i && to_idle_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= park_d;
   end

   generate
      for (genvar i = 1; i < PAR_LAG; i++) begin : g_lag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= park_d && chain_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_q <= 1'b0;
      else        par_q <= park_d && chain_q[PAR_LAG-1];
   end

   assign parked_o = chain_q[0];
   assign ad_oe_o  = chain_q[0];
   assign cbe_oe_o = chain_q[0];
   assign par_oe_o = par_q;

endmodule

// File: rtl/bus_own_spare.sv
module bus_own_spare #(
   parameter int N_SPARE = 8
) (
   output logic [N_SPARE-1:0] spare_gnt_n_o
);

   generate
      for (genvar i = 0; i < N_SPARE; i++) begin : g_spare
         assign spare_gnt_n_o[i] = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/bus_own_ctl.sv
module bus_own_ctl
   import bus_own_pkg::*;
#(
   parameter int AD_W    = 32,
   parameter int CBE_W   = 4,
   parameter int N_SPARE = 8,
   parameter int PAR_LAG = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mst_req_i,
   input  logic               gnt_n_i,
   input  logic               frame_n_i,
   input  logic               irdy_n_i,
   output logic               req_n_o,
   output logic               start_o,
   output logic               ad_oe_o,
   output logic               cbe_oe_o,
   output logic               par_oe_o,
   output logic [AD_W-1:0]    park_ad_o,
   output logic [CBE_W-1:0]   park_cbe_o,
   output logic               park_par_o,
   output logic [N_SPARE-1:0] spare_gnt_n_o
);

   localparam int BYTES = AD_W / 8;

   initial begin
      if (AD_W < 8 || AD_W > 64 || (AD_W % 8) != 0)
         $error("bus_own_ctl: AD_W must be a multiple of 8 from 8 to 64");
      if (CBE_W != BYTES)
         $error("bus_own_ctl: CBE_W must equal AD_W/8");
      if (N_SPARE < 1)
         $error("bus_own_ctl: N_SPARE must be at least 1");
      if (PAR_LAG < 1)
         $error("bus_own_ctl: PAR_LAG must be at least 1");
   end

   logic idle;
   logic req_d;
   logic to_idle;
   logic parked;

   assign idle = frame_n_i && irdy_n_i;

   bus_own_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mst_req_i (mst_req_i),
      .gnt_n_i   (gnt_n_i),
      .idle_i    (idle),
      .frame_n_i (frame_n_i),
      .parked_i  (parked),
      .req_d_o   (req_d),
      .to_idle_o (to_idle),
      .req_n_o   (req_n_o),
      .start_o   (start_o)
   );

   bus_own_park #(.PAR_LAG(PAR_LAG)) u_park (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_n_i   (gnt_n_i),
      .idle_i    (idle),
      .req_d_i   (req_d),
      .to_idle_i (to_idle),
      .parked_o  (parked),
      .ad_oe_o   (ad_oe_o),
      .cbe_oe_o  (cbe_oe_o),
      .par_oe_o  (par_oe_o)
   );

   bus_own_spare #(.N_SPARE(N_SPARE)) u_spare (
      .spare_gnt_n_o (spare_gnt_n_o)
   );

   assign park_ad_o  = '0;
   assign park_cbe_o = '0;
   assign park_par_o = even_par(64'(park_ad_o), 8'(park_cbe_o));

endmodule

// File: rtl/bus_own_ctl_chk.sv
module bus_own_ctl_chk #(
   parameter int N_SPARE = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               gnt_n_i,
   input logic               frame_n_i,
   input logic               irdy_n_i,
   input logic               req_n_o,
   input logic               start_o,
   input logic               ad_oe_o,
   input logic               cbe_oe_o,
   input logic               par_oe_o,
   input logic               park_par_o,
   input logic [N_SPARE-1:0] spare_gnt_n_o
);

   p_no_park_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n_i || !irdy_n_i) |=> !ad_oe_o);

   p_no_park_requesting_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe_o |-> req_n_o);

   p_par_after_ad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_oe_o) |-> $past(ad_oe_o));

   p_par_needs_ad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe_o |-> ad_oe_o && cbe_oe_o);

   p_release_on_gnt_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_n_i |=> !ad_oe_o && !cbe_oe_o && !par_oe_o);

   p_start_with_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !req_n_o);

   p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   p_start_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_o) |-> $past(!gnt_n_i && frame_n_i && irdy_n_i));

   p_spare_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      &spare_gnt_n_o && !park_par_o);

endmodule

bind bus_own_ctl bus_own_ctl_chk #(.N_SPARE(N_SPARE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .gnt_n_i       (gnt_n_i),
   .frame_n_i     (frame_n_i),
   .irdy_n_i      (irdy_n_i),
   .req_n_o       (req_n_o),
   .start_o       (start_o),
   .ad_oe_o       (ad_oe_o),
   .cbe_oe_o      (cbe_oe_o),
   .par_oe_o      (par_oe_o),
   .park_par_o    (park_par_o),
   .spare_gnt_n_o (spare_gnt_n_o)
);

// File: tb/bus_own_ctl_bench.sv
module bus_own_ctl_bench;

   localparam int AD_W    = 32;
   localparam int CBE_W   = 4;
   localparam int N_SPARE = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               mst_req = 1'b0;
   logic               gnt_n = 1'b1;
   logic               frame_n = 1'b1;
   logic               irdy_n = 1'b1;
   logic               req_n, start, ad_oe, cbe_oe, par_oe, park_par;
   logic [AD_W-1:0]    park_ad;
   logic [CBE_W-1:0]   park_cbe;
   logic [N_SPARE-1:0] spare_gnt_n;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic  req_n;
      logic  start;
      logic  ad;
      logic  par;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #10 clk = ~clk;

   bus_own_ctl #(.AD_W(AD_W), .CBE_W(CBE_W), .N_SPARE(N_SPARE)) u_bus_own_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .mst_req_i     (mst_req),
      .gnt_n_i       (gnt_n),
      .frame_n_i     (frame_n),
      .irdy_n_i      (irdy_n),
      .req_n_o       (req_n),
      .start_o       (start),
      .ad_oe_o       (ad_oe),
      .cbe_oe_o      (cbe_oe),
      .par_oe_o      (par_oe),
      .park_ad_o     (park_ad),
      .park_cbe_o    (park_cbe),
      .park_par_o    (park_par),
      .spare_gnt_n_o (spare_gnt_n)
   );

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %s expected %s", tag, act, exp);
      end
   endtask

   // driver: apply inputs at the falling edge, expect outputs after the next rising edge
   task automatic step(input logic mr, input logic g, input logic fr, input logic ir,
                       input logic e_req_n, input logic e_start, input logic e_ad,
                       input logic e_par, input string tag);
      exp_t e;
      @(negedge clk);
      mst_req = mr; gnt_n = g; frame_n = fr; irdy_n = ir;
      e.req_n = e_req_n; e.start = e_start; e.ad = e_ad; e.par = e_par; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(req_n === e.req_n && start === e.start && ad_oe === e.ad &&
                  cbe_oe === e.ad && par_oe === e.par && &spare_gnt_n,
                  e.tag,
                  $sformatf("req_n=%b start=%b ad=%b cbe=%b par=%b spare=%b",
                            req_n, start, ad_oe, cbe_oe, par_oe, spare_gnt_n),
                  $sformatf("req_n=%b start=%b ad=%b cbe=%b par=%b spare=all1",
                            e.req_n, e.start, e.ad, e.ad, e.par));
         end
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            check(req_n === 1'b1 && start === 1'b0 && ad_oe === 1'b0 && cbe_oe === 1'b0 &&
                  par_oe === 1'b0 && &spare_gnt_n, "R1 reset",
                  $sformatf("%b%b%b%b%b %b", req_n, start, ad_oe, cbe_oe, par_oe, spare_gnt_n),
                  "10000 all1");
            check(park_ad === '0 && park_cbe === '0 && park_par === 1'b0, "R9 park values",
                  $sformatf("%h %h %b", park_ad, park_cbe, park_par), "0 0 0");
            rst_n = 1'b1;

            // parking with two-stage enables
            step(0, 0, 1, 1, 1, 0, 1, 0, "R2 park ad/cbe enabled");
            step(0, 0, 1, 1, 1, 0, 1, 1, "R3 parity one clock later");
            step(0, 1, 1, 1, 1, 0, 0, 0, "R4 release after grant lost");
            // busy bus blocks parking
            step(0, 0, 0, 1, 1, 0, 0, 0, "R2 no park while frame low");
            step(0, 0, 1, 0, 1, 0, 0, 0, "R2 no park while ready low");
            step(0, 0, 1, 1, 1, 0, 1, 0, "R3 parity held back");
            step(0, 0, 1, 1, 1, 0, 1, 1, "R3 parity follows");
            // direct start from the parked state
            step(1, 0, 1, 1, 0, 1, 0, 0, "R7 start from parked");
            step(0, 0, 0, 1, 1, 0, 0, 0, "R8 request dropped after frame");
            step(0, 0, 0, 0, 1, 0, 0, 0, "R8 no park during transfer");
            step(0, 0, 1, 1, 1, 0, 1, 0, "R2 park again after transfer");
            // request without grant
            step(0, 1, 1, 1, 1, 0, 0, 0, "R4 release");
            step(1, 1, 1, 1, 0, 0, 0, 0, "R5 request asserted");
            step(1, 1, 1, 1, 0, 0, 0, 0, "R5 request held without grant");
            step(1, 0, 0, 1, 0, 0, 0, 0, "R6 no start on busy bus");
            step(1, 0, 1, 1, 0, 1, 0, 0, "R6 start after idle grant");
            step(1, 0, 0, 1, 0, 0, 0, 0, "R8 queued keeps request");
            step(1, 0, 1, 1, 0, 0, 0, 0, "R8 re-arbitrate after idle");
            step(1, 0, 1, 1, 0, 1, 0, 0, "R8 second start");
            step(0, 0, 0, 1, 1, 0, 0, 0, "R8 request released");
            step(0, 1, 1, 1, 1, 0, 0, 0, "R4 no park without grant");
            // withdraw before start
            step(1, 1, 1, 1, 0, 0, 0, 0, "R5 request again");
            step(0, 1, 1, 1, 1, 0, 0, 0, "R5 withdrawn request");
            step(0, 1, 1, 1, 1, 0, 0, 0, "R9 idle, spare high");
            @(negedge clk);
            @(negedge clk);
         end
         begin
            repeat (2000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule